// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block guards the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no operand forwarding. The register file is read in decode and written in writeback. An instruction in decode can therefore read a register that an older instruction still in flight has not yet written. The controller compares each source register number in decode with the destination register numbers of the three older instructions held in the execute, memory and writeback pipeline registers. A comparison counts only when the older instruction will actually write a register.

When any comparison matches, the controller holds the program counter and the fetch/decode register. The decode instruction is then examined again on the next cycle. At the same time the controller replaces the control word entering the execute stage with a bubble whose memory-write and register-write bits are cleared. The outputs are combinational and respond in the same cycle as the inputs. The stall therefore repeats every cycle until the producer has left the last compared stage. A parameter drops the writeback comparison for register files that write in the first half of the cycle and read in the second.

Top module: `raw_interlock_ctrl`

## Requirements
- R1: When operand A is read (`dec_use_a`=1), `dec_src_a` is nonzero and it equals the destination of any compared stage whose write enable is 1, the block stalls in the same cycle: `pc_we`=0, `fd_we`=0, `bubble_sel`=1.
- R2: The rule of R1 applies equally to operand B (`dec_use_b`, `dec_src_b`), on its own and together with operand A.
- R3: A source register number of 0 never causes a stall, even when a writing stage targets register 0.
- R4: An operand whose use flag is 0 never causes a stall, whatever its register number.
- R5: A stage whose write enable is 0, such as a store or a bubble, never counts as a producer.
- R6: While `bubble_sel`=1, both `ex_mem_wr` and `ex_reg_wr` are 0, whatever the decode control inputs are.
- R7: Without a stall, `pc_we`=1, `fd_we`=1 and `bubble_sel`=0, and `ex_mem_wr`/`ex_reg_wr` equal `dec_mem_wr`/`dec_reg_wr`.
- R8: With `HALF_CYCLE_RF`=0 (the default), the writeback-stage destination is compared. With `HALF_CYCLE_RF`=1 it is ignored, so a match found only at writeback does not stall.
- R9: In a pipeline whose stage registers advance every cycle and take the bubble on a stall, a consumer that directly follows its producer stalls 3 cycles. With 1, 2 or 3 independent instructions between them it stalls 2, 1 or 0 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only for the timed checks |
| rst_n | input | 1 | Asynchronous active-low reset; it gates the timed checks |
| dec_src_a | input | AW | Operand A register number of the decode instruction |
| dec_src_b | input | AW | Operand B register number of the decode instruction |
| dec_use_a | input | 1 | Decode instruction reads operand A |
| dec_use_b | input | 1 | Decode instruction reads operand B |
| dec_mem_wr | input | 1 | Memory-write control of the decode instruction |
| dec_reg_wr | input | 1 | Register-write control of the decode instruction |
| dx_dst | input | AW | Destination register in the decode/execute register |
| dx_we | input | 1 | Register-write enable in the decode/execute register |
| xm_dst | input | AW | Destination register in the execute/memory register |
| xm_we | input | 1 | Register-write enable in the execute/memory register |
| mw_dst | input | AW | Destination register in the memory/writeback register |
| mw_we | input | 1 | Register-write enable in the memory/writeback register |
| pc_we | output | 1 | Program counter update enable |
| fd_we | output | 1 | Fetch/decode register load enable |
| bubble_sel | output | 1 | Selects the bubble into the execute stage |
| ex_mem_wr | output | 1 | Memory-write control sent into the execute stage |
| ex_reg_wr | output | 1 | Register-write control sent into the execute stage |

## Verification
Two matches can occur in the same cycle: operand A against one stage and operand B against another. The bench provokes this with operand A matching the execute stage and operand B matching writeback, and expects a single stall with the bubble cleared. The freeze and the bubble are also judged together. Every stalled vector drives both decode write controls high and expects the hold enables and the execute-stage controls all low in the same cycle. A small pipeline model in the bench then moves a producer through the stages to judge the stall lengths of R9.

// File: rtl/raw_pkg.sv
package raw_pkg;
  // Number of older pipeline stages that may hold a producer.
  localparam int NUM_PROD = 3;

  // Index of each producer stage inside the comparison vectors.
  typedef enum logic [1:0] {
    PROD_DX = 2'd0,
    PROD_XM = 2'd1,
    PROD_MW = 2'd2
  } prod_stage_e;

  // Control bits that a bubble must clear.
  typedef struct packed {
    logic mem_wr;
    logic reg_wr;
  } side_ctrl_t;
endpackage

// File: rtl/raw_dst_cmp.sv
// One source-versus-destination comparator.
module raw_dst_cmp #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst,
  input  logic          dst_we,
  output logic          hit
);
  logic src_live;

  always_comb begin
    src_live = src_used && (src != '0);
    hit      = src_live && dst_we && (src == dst);
  end
endmodule

// File: rtl/raw_operand_scan.sv
// Compares one decode operand with every producer stage.
module raw_operand_scan #(
  parameter int AW    = 5,
  parameter int NPROD = 3
) (
  input  logic [AW-1:0]       src,
  input  logic                src_used,
  input  logic [NPROD*AW-1:0] dst_vec,
  input  logic [NPROD-1:0]    we_vec,
  output logic                any_hit
);
  logic [NPROD-1:0] stage_hit;

  for (genvar s = 0; s < NPROD; s++) begin : g_stage
    raw_dst_cmp #(.AW(AW)) u_cmp (
      .src      (src),
      .src_used (src_used),
      .dst      (dst_vec[s*AW +: AW]),
      .dst_we   (we_vec[s]),
      .hit      (stage_hit[s])
    );
  end

  assign any_hit = |stage_hit;
endmodule

// File: rtl/raw_bubble_gen.sv
// Turns the hazard flag into hold enables and the execute-stage control.
module raw_bubble_gen
  import raw_pkg::*;
(
  input  logic       hazard,
  input  side_ctrl_t dec_ctrl,
  output logic       pc_hold_n,
  output logic       fd_hold_n,
  output logic       bubble,
  output side_ctrl_t ex_ctrl
);
  always_comb begin
    pc_hold_n = !hazard;
    fd_hold_n = !hazard;
    bubble    = hazard;
    if (hazard) begin
      ex_ctrl = '0;
    end else begin
      ex_ctrl = dec_ctrl;
    end
  end
endmodule

// File: rtl/raw_interlock_ctrl.sv
module raw_interlock_ctrl
  import raw_pkg::*;
#(
  parameter int AW            = 5,
  parameter bit HALF_CYCLE_RF = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_use_a,
  input  logic          dec_use_b,
  input  logic          dec_mem_wr,
  input  logic          dec_reg_wr,
  input  logic [AW-1:0] dx_dst,
  input  logic          dx_we,
  input  logic [AW-1:0] xm_dst,
  input  logic          xm_we,
  input  logic [AW-1:0] mw_dst,
  input  logic          mw_we,
  output logic          pc_we,
  output logic          fd_we,
  output logic          bubble_sel,
  output logic          ex_mem_wr,
  output logic          ex_reg_wr
);
  localparam int  NPROD    = NUM_PROD;
  localparam bit  CHECK_MW = !HALF_CYCLE_RF;

  logic [NPROD*AW-1:0] dst_vec;
  logic [NPROD-1:0]    we_vec;
  logic                hit_a;
  logic                hit_b;
  logic                hazard;
  side_ctrl_t          dec_ctrl;
  side_ctrl_t          ex_ctrl;

  // Producer vectors, indexed by stage.
  always_comb begin
    dst_vec = '0;
    we_vec  = '0;
    dst_vec[PROD_DX*AW +: AW] = dx_dst;
    dst_vec[PROD_XM*AW +: AW] = xm_dst;
    dst_vec[PROD_MW*AW +: AW] = mw_dst;
    we_vec[PROD_DX] = dx_we;
    we_vec[PROD_XM] = xm_we;
    we_vec[PROD_MW] = mw_we && CHECK_MW;
  end

  raw_operand_scan #(.AW(AW), .NPROD(NPROD)) u_scan_a (
    .src      (dec_src_a),
    .src_used (dec_use_a),
    .dst_vec  (dst_vec),
    .we_vec   (we_vec),
    .any_hit  (hit_a)
  );

  raw_operand_scan #(.AW(AW), .NPROD(NPROD)) u_scan_b (
    .src      (dec_src_b),
    .src_used (dec_use_b),
    .dst_vec  (dst_vec),
    .we_vec   (we_vec),
    .any_hit  (hit_b)
  );

  assign hazard          = hit_a || hit_b;
  assign dec_ctrl.mem_wr = dec_mem_wr;
  assign dec_ctrl.reg_wr = dec_reg_wr;

  raw_bubble_gen u_bubble (
    .hazard    (hazard),
    .dec_ctrl  (dec_ctrl),
    .pc_hold_n (pc_we),
    .fd_hold_n (fd_we),
    .bubble    (bubble_sel),
    .ex_ctrl   (ex_ctrl)
  );

  assign ex_mem_wr = ex_ctrl.mem_wr;
  assign ex_reg_wr = ex_ctrl.reg_wr;

  // Operand A against the execute-stage producer must freeze the front end.
  assert_srca_dx_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_use_a && dec_src_a != '0 && dx_we && dec_src_a == dx_dst)
      |-> (bubble_sel && !pc_we && !fd_we));

  // Operand B against the memory-stage producer must freeze the front end.
  assert_srcb_xm_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_use_b && dec_src_b != '0 && xm_we && dec_src_b == xm_dst)
      |-> (bubble_sel && !pc_we && !fd_we));

  // Zero or unread sources on both operands never stall (R3, R4).
  assert_quiet_sources_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!dec_use_a || dec_src_a == '0) && (!dec_use_b || dec_src_b == '0))
      |-> (pc_we && fd_we && !bubble_sel));

  // No writing stage downstream means no stall.
  assert_no_producer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dx_we && !xm_we && !mw_we) |-> !bubble_sel);

  // A bubble carries no write side effects.
  assert_bubble_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!ex_mem_wr && !ex_reg_wr));

  // Without a bubble the decode controls pass unchanged.
  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |-> (pc_we && fd_we && ex_mem_wr == dec_mem_wr && ex_reg_wr == dec_reg_wr));
endmodule

// File: tb/raw_interlock_ctrl_test.sv
module raw_interlock_ctrl_test;
  localparam int AW   = 5;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] dec_src_a, dec_src_b, dx_dst, xm_dst, mw_dst;
  logic dec_use_a, dec_use_b, dec_mem_wr, dec_reg_wr, dx_we, xm_we, mw_we;
  logic pc_we, fd_we, bubble_sel, ex_mem_wr, ex_reg_wr;
  logic s_pc_we, s_fd_we, s_bubble_sel, s_ex_mem_wr, s_ex_reg_wr;

  int nchecks = 0;
  int nerrors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  raw_interlock_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .dec_mem_wr(dec_mem_wr), .dec_reg_wr(dec_reg_wr),
    .dx_dst(dx_dst), .dx_we(dx_we), .xm_dst(xm_dst), .xm_we(xm_we),
    .mw_dst(mw_dst), .mw_we(mw_we),
    .pc_we(pc_we), .fd_we(fd_we), .bubble_sel(bubble_sel),
    .ex_mem_wr(ex_mem_wr), .ex_reg_wr(ex_reg_wr)
  );

  raw_interlock_ctrl #(.AW(AW), .HALF_CYCLE_RF(1'b1)) uut_split (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .dec_mem_wr(dec_mem_wr), .dec_reg_wr(dec_reg_wr),
    .dx_dst(dx_dst), .dx_we(dx_we), .xm_dst(xm_dst), .xm_we(xm_we),
    .mw_dst(mw_dst), .mw_we(mw_we),
    .pc_we(s_pc_we), .fd_we(s_fd_we), .bubble_sel(s_bubble_sel),
    .ex_mem_wr(s_ex_mem_wr), .ex_reg_wr(s_ex_reg_wr)
  );

  // Vector layout: sa[30:26] sb[25:21] ua[20] ub[19] dxd[18:14] dxw[13]
  // xmd[12:8] xmw[7] mwd[6:2] mww[1] expected_stall[0]
  function automatic logic [30:0] mk(input int sa, input int sb, input int ua, input int ub,
                                     input int dxd, input int dxw, input int xmd, input int xmw,
                                     input int mwd, input int mww, input int ex);
    logic [4:0] a5, b5, d5, x5, m5;
    a5 = sa[4:0]; b5 = sb[4:0]; d5 = dxd[4:0]; x5 = xmd[4:0]; m5 = mwd[4:0];
    return {a5, b5, ua[0], ub[0], d5, dxw[0], x5, xmw[0], m5, mww[0], ex[0]};
  endfunction

  localparam logic [30:0] VEC [NVEC] = '{
    mk(3, 0, 1, 0, 3, 1, 0, 0, 0, 0, 1),
    mk(4, 0, 1, 0, 0, 0, 4, 1, 0, 0, 1),
    mk(7, 0, 1, 0, 0, 0, 0, 0, 7, 1, 1),
    mk(0, 9, 0, 1, 9, 1, 0, 0, 0, 0, 1),
    mk(0, 2, 0, 1, 0, 0, 0, 0, 2, 1, 1),
    mk(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0),
    mk(0, 0, 0, 1, 0, 0, 0, 1, 0, 1, 0),
    mk(3, 0, 0, 0, 3, 1, 0, 0, 0, 0, 0),
    mk(0, 6, 0, 0, 0, 0, 6, 1, 0, 0, 0),
    mk(3, 0, 1, 0, 3, 0, 0, 0, 0, 0, 0),
    mk(0, 5, 0, 1, 0, 0, 5, 0, 5, 0, 0),
    mk(1, 2, 1, 1, 3, 1, 4, 1, 5, 1, 0),
    mk(8, 9, 1, 1, 8, 1, 0, 0, 9, 1, 1)
  };

  localparam string TAG [NVEC] = '{
    "R1 srcA vs execute", "R1 srcA vs memory", "R1 srcA vs writeback",
    "R2 srcB vs execute", "R2 srcB vs writeback",
    "R3 srcA zero", "R3 srcB zero",
    "R4 srcA unread", "R4 srcB unread",
    "R5 execute not writing", "R5 memory and writeback not writing",
    "R7 no match", "R2 both operands matched"
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {27'd0, pc_we, fd_we, bubble_sel, ex_mem_wr, ex_reg_wr};
  endfunction

  task automatic idle_inputs();
    dec_src_a = '0; dec_src_b = '0; dec_use_a = 0; dec_use_b = 0;
    dec_mem_wr = 0; dec_reg_wr = 0;
    dx_dst = '0; dx_we = 0; xm_dst = '0; xm_we = 0; mw_dst = '0; mw_we = 0;
  endtask

  // R9: producer writes r5, then gap independent instructions, then a reader of r5.
  task automatic run_chain(input int gap, input int exp_stall);
    int idx = 0;
    int stalls = 0;
    logic [AW-1:0] m_dxd = '0, m_xmd = '0, m_mwd = '0, cur_dst;
    logic m_dxw = 0, m_xmw = 0, m_mww = 0;
    for (int cyc = 0; cyc < 24 && idx <= gap + 1; cyc++) begin
      @(negedge clk);
      idle_inputs();
      cur_dst = '0;
      if (idx == 0) begin
        dec_reg_wr = 1; cur_dst = 5'd5;
      end else if (idx == gap + 1) begin
        dec_src_a = 5'd5; dec_use_a = 1;
      end
      dx_dst = m_dxd; dx_we = m_dxw; xm_dst = m_xmd; xm_we = m_xmw;
      mw_dst = m_mwd; mw_we = m_mww;
      #2;
      if (bubble_sel && idx == gap + 1) stalls++;
      m_mwd = m_xmd; m_mww = m_xmw;
      m_xmd = m_dxd; m_xmw = m_dxw;
      m_dxd = bubble_sel ? '0 : cur_dst;
      m_dxw = ex_reg_wr;
      if (fd_we) idx++;
    end
    check(stalls == exp_stall, $sformatf("R9 stall length with gap %0d", gap), stalls, exp_stall);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nerrors++;
      nchecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outs() == 5'b11000, "R7 state during reset", outs(), 5'b11000);
    rst_n = 1'b1;

    // Table walk: both decode write controls high, so a stall must clear them.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      dec_src_a  = VEC[i][30:26]; dec_src_b = VEC[i][25:21];
      dec_use_a  = VEC[i][20];    dec_use_b = VEC[i][19];
      dx_dst     = VEC[i][18:14]; dx_we     = VEC[i][13];
      xm_dst     = VEC[i][12:8];  xm_we     = VEC[i][7];
      mw_dst     = VEC[i][6:2];   mw_we     = VEC[i][1];
      dec_mem_wr = 1; dec_reg_wr = 1;
      #2;
      check(outs() == (VEC[i][0] ? 5'b00100 : 5'b11011),
            $sformatf("%s (R6 R7 outputs)", TAG[i]), outs(),
            VEC[i][0] ? 5'b00100 : 5'b11011);
    end

    // R8: a match found only at writeback is ignored by the half-cycle variant.
    @(negedge clk);
    idle_inputs();
    dec_src_a = 5'd7; dec_use_a = 1; mw_dst = 5'd7; mw_we = 1; dec_reg_wr = 1;
    #2;
    check(bubble_sel == 1'b1, "R8 default compares writeback", bubble_sel, 1);
    check({s_pc_we, s_fd_we, s_bubble_sel, s_ex_reg_wr} == 4'b1101,
          "R8 half-cycle variant ignores writeback",
          {s_pc_we, s_fd_we, s_bubble_sel, s_ex_reg_wr}, 4'b1101);

    // R8: the half-cycle variant still compares the execute stage.
    @(negedge clk);
    idle_inputs();
    dec_src_b = 5'd11; dec_use_b = 1; dx_dst = 5'd11; dx_we = 1;
    #2;
    check(s_bubble_sel == 1'b1, "R8 half-cycle variant compares execute", s_bubble_sel, 1);

    // R7: pass-through of a mixed control word with no stall.
    @(negedge clk);
    idle_inputs();
    dec_src_a = 5'd2; dec_use_a = 1; dx_dst = 5'd3; dx_we = 1;
    dec_mem_wr = 1; dec_reg_wr = 0;
    #2;
    check(outs() == 5'b11010, "R7 store control passes", outs(), 5'b11010);

    // R3: register 0 written by every stage, both operands read register 0.
    @(negedge clk);
    idle_inputs();
    dec_use_a = 1; dec_use_b = 1; dx_we = 1; xm_we = 1; mw_we = 1;
    #2;
    check(bubble_sel == 1'b0, "R3 register zero everywhere", bubble_sel, 0);

    // R9: stall lengths against distance to the producer.
    for (int g = 0; g < 4; g++) begin
      run_chain(g, 3 - g);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule